// File: doc/BRIEF.md
# Integer-plus-Fractional Clock Divider

This block divides one source clock by a programmable ratio made of an integer part and a fraction in thirty-seconds. Its average output period is (1 + INT) + FRAC/32 source cycles. It produces two outputs. The first is a single-cycle `tick_o` strobe on the last source cycle of every divided period. The second is an optional 50/50 `divclk_o` level, driven only for pure integer ratios of two or more. The fraction comes from a small phase accumulator. When that accumulator carries out at the end of a period, the next period is one source cycle longer. The average ratio is therefore exact, at the cost of one cycle of period jitter.

Software reaches the block through a single 32-bit control word, which holds the run status, the fraction and the integer. The run status is not writable through that word. It moves only through separate start and stop command inputs, and stop wins when both are asserted together. A wake-up input returns the period counter and the accumulator to zero and leaves the configuration and the run status untouched, so the divider runs again without being restarted. A new ratio written while the divider runs takes effect at the next period boundary.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the control word reads 0x00000000, and `tick_o` and `divclk_o` are low.
- R2: The control word carries the run status in bit 0, FRAC in bits 7:3 and INT in bits 31:8. Bits 2:1 always read 0. A write updates FRAC and INT on the next clock edge.
- R3: Bit 0 of a written word is discarded. A start command sets the status on the next edge and a stop command clears it. When both commands arrive in the same cycle the status ends up 0.
- R4: With FRAC = 0, `tick_o` is high for exactly one source cycle and repeats every 1 + INT source cycles.
- R5: At each period end FRAC is added to a 5-bit accumulator. A carry makes the next period 2 + INT cycles. Any 32 consecutive periods therefore total 32·(1 + INT) + FRAC cycles.
- R6: With FRAC = 0 and INT ≥ 1, `divclk_o` is high for the first floor((1 + INT)/2) cycles of each period, starting the cycle after a tick, and low for the rest of the period.
- R7: `divclk_o` stays low whenever the ratio in force has a nonzero FRAC or INT = 0. With INT = 0 and FRAC = 0, `tick_o` is high in every cycle.
- R8: While the status is 0 both outputs are low and the counters are held at zero. The first tick after a start command comes 1 + INT cycles after the start edge.
- R9: A ratio written while running does not change the period in progress. It takes effect from the next period.
- R10: A wake-up pulse suppresses the tick in its own cycle and restarts the period from count zero. The control word is unchanged, so the next tick comes 1 + INT cycles after the wake-up edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word write data |
| cmd_start_i | input | 1 | Start command, sets run status |
| cmd_stop_i | input | 1 | Stop command, clears run status (priority) |
| wake_i | input | 1 | Wake-up event, restarts counters, keeps configuration |
| cfg_rdata_o | output | 32 | Control word read value |
| tick_o | output | 1 | One-cycle strobe at each period end |
| divclk_o | output | 1 | 50/50 divided clock for integer ratios ≥ 2 |

## Verification
Two cases are the hardest to reach from the ports. One is a new ratio arriving partway through a period. The other is a wake-up event hitting a running divider. In both, the effect shows only in the timing of later ticks, because the control word looks unchanged. The stimulus therefore records the cycle of each start, write and wake-up, and lets the divider run for several periods afterwards. It then checks the measured distances between ticks against the old and new ratios. For the fractional case it collects 33 consecutive ticks and compares the sum of the 32 gaps with the exact total that R5 predicts.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Control word layout: bit positions other blocks decode.
  localparam int STAT_POS = 0;
  localparam int FRAC_POS = 3;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_SET  = 2'd1,
    CMD_CLR  = 2'd2
  } run_cmd_e;

  // Stop wins over start.
  function automatic run_cmd_e decode_cmd(input logic start, input logic stop);
    if (stop)       return CMD_CLR;
    else if (start) return CMD_SET;
    else            return CMD_IDLE;
  endfunction

endpackage

// File: rtl/fcd_ctl_reg.sv
module fcd_ctl_reg
  import fcd_pkg::*;
#(
  parameter  int INT_W   = 24,
  parameter  int FRAC_W  = 5,
  localparam int INT_LSB = FRAC_POS + FRAC_W,
  localparam int WORD_W  = INT_LSB + INT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              en_o,
  output logic              en_next_o,
  output logic [WORD_W-1:0] rdata_o
);

  logic [INT_W-1:0]    int_q;
  logic [FRAC_W-1:0]   frac_q;
  logic                en_q;
  logic                en_d;
  run_cmd_e            cmd;
  // Status and spare bits of a written word are discarded on purpose.
  logic [FRAC_POS-1:0] wr_low_unused;

  assign wr_low_unused = wdata_i[FRAC_POS-1:0];
  assign cmd           = decode_cmd(cmd_start_i, cmd_stop_i);

  always_comb begin
    unique case (cmd)
      CMD_SET: en_d = 1'b1;
      CMD_CLR: en_d = 1'b0;
      default: en_d = en_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= '0;
      frac_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en_d;
      if (we_i) begin
        int_q  <= wdata_i[INT_LSB +: INT_W];
        frac_q <= wdata_i[FRAC_POS +: FRAC_W];
      end
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[STAT_POS]            = en_q;
    rdata_o[FRAC_POS +: FRAC_W]  = frac_q;
    rdata_o[INT_LSB +: INT_W]    = int_q;
  end

  assign int_o     = int_q;
  assign frac_o    = frac_q;
  assign en_o      = en_q;
  assign en_next_o = en_d;

endmodule

// File: rtl/fcd_frac_acc.sv
module fcd_frac_acc #(
  parameter int FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              ext_o,
  output logic [FRAC_W-1:0] acc_o
);

  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic [FRAC_W:0]   step;

  // Phase step: returns {carry, new phase}.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] ph,
                                                input logic [FRAC_W-1:0] inc);
    return {1'b0, ph} + {1'b0, inc};
  endfunction

  assign step = frac_step(acc_q, frac_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (adv_i) begin
      acc_q <= step[FRAC_W-1:0];
      ext_q <= step[FRAC_W];
    end
  end

  assign ext_o = ext_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/fcd_period_gen.sv
module fcd_period_gen #(
  parameter int INT_W      = 24,
  parameter int FRAC_W     = 5,
  parameter bit HAS_DIVCLK = 1'b1,
  localparam int CNT_W     = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              en_next_i,
  input  logic              wake_i,
  input  logic [INT_W-1:0]  cfg_int_i,
  input  logic [FRAC_W-1:0] cfg_frac_i,
  input  logic              ext_i,
  output logic              tick_o,
  output logic              hold_o,
  output logic              divclk_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  last_o,
  output logic [FRAC_W-1:0] act_frac_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [INT_W-1:0]  act_int_q, act_int_d;
  logic [FRAC_W-1:0] act_frac_q, act_frac_d;
  logic              hold;
  logic              tick;
  logic [CNT_W-1:0]  last_pos;

  // Final count of a period: INT plus a possible one-cycle stretch.
  function automatic logic [CNT_W-1:0] period_last(input logic [INT_W-1:0] n,
                                                   input logic ext);
    return {1'b0, n} + {{(CNT_W-1){1'b0}}, ext};
  endfunction

  // High phase length of the even clock: floor((1+INT)/2).
  function automatic logic [CNT_W-1:0] high_len(input logic [INT_W-1:0] n);
    return ({1'b0, n} + 1'b1) >> 1;
  endfunction

  function automatic logic even_ok(input logic [INT_W-1:0] n,
                                   input logic [FRAC_W-1:0] f);
    return (f == '0) && (n != '0);
  endfunction

  assign hold     = !en_i || wake_i;
  assign last_pos = period_last(act_int_q, ext_i);
  assign tick     = !hold && (cnt_q == last_pos);

  always_comb begin
    if (hold || tick) begin
      cnt_d      = '0;
      act_int_d  = cfg_int_i;
      act_frac_d = cfg_frac_i;
    end else begin
      cnt_d      = cnt_q + 1'b1;
      act_int_d  = act_int_q;
      act_frac_d = act_frac_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      act_int_q  <= '0;
      act_frac_q <= '0;
    end else begin
      cnt_q      <= cnt_d;
      act_int_q  <= act_int_d;
      act_frac_q <= act_frac_d;
    end
  end

  generate
    if (HAS_DIVCLK) begin : g_divclk
      // Registered from next-state values, so the level lines up with cnt_q.
      logic divclk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) divclk_q <= 1'b0;
        else         divclk_q <= en_next_i && even_ok(act_int_d, act_frac_d) &&
                                 (cnt_d < high_len(act_int_d));
      end
      assign divclk_o = divclk_q;
    end else begin : g_no_divclk
      assign divclk_o = 1'b0;
    end
  endgenerate

  assign tick_o     = tick;
  assign hold_o     = hold;
  assign cnt_o      = cnt_q;
  assign last_o     = last_pos;
  assign act_frac_o = act_frac_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter  int INT_W      = 24,
  parameter  int FRAC_W     = 5,
  parameter  bit HAS_DIVCLK = 1'b1,
  localparam int WORD_W     = FRAC_POS + FRAC_W + INT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              wake_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  output logic              tick_o,
  output logic              divclk_o
);

  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  cfg_int;
  logic [FRAC_W-1:0] cfg_frac;
  logic              run_en;
  logic              run_en_next;
  logic              period_end;
  logic              cnt_hold;
  logic              stretch;
  logic [FRAC_W-1:0] phase_unused;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  last_w;
  logic [FRAC_W-1:0] act_frac_w;

  fcd_ctl_reg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .cmd_start_i(cmd_start_i),
    .cmd_stop_i (cmd_stop_i),
    .int_o      (cfg_int),
    .frac_o     (cfg_frac),
    .en_o       (run_en),
    .en_next_o  (run_en_next),
    .rdata_o    (cfg_rdata_o)
  );

  fcd_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_hold),
    .adv_i (period_end),
    .frac_i(act_frac_w),
    .ext_o (stretch),
    .acc_o (phase_unused)
  );

  fcd_period_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .HAS_DIVCLK(HAS_DIVCLK)) u_per (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run_en),
    .en_next_i (run_en_next),
    .wake_i    (wake_i),
    .cfg_int_i (cfg_int),
    .cfg_frac_i(cfg_frac),
    .ext_i     (stretch),
    .tick_o    (period_end),
    .hold_o    (cnt_hold),
    .divclk_o  (divclk_o),
    .cnt_o     (cnt_w),
    .last_o    (last_w),
    .act_frac_o(act_frac_w)
  );

  assign tick_o = period_end;

endmodule

// File: rtl/fcd_sva.sv
module fcd_sva #(
  parameter  int INT_W  = 24,
  parameter  int FRAC_W = 5,
  localparam int WORD_W = 3 + FRAC_W + INT_W,
  localparam int CNT_W  = INT_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              cmd_start_i,
  input logic              cmd_stop_i,
  input logic              wake_i,
  input logic [WORD_W-1:0] cfg_rdata_o,
  input logic              tick_o,
  input logic              divclk_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  last_w,
  input logic [FRAC_W-1:0] act_frac_w
);

  p_stop_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stop_i |=> !cfg_rdata_o[0]);

  p_start_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && !cmd_stop_i) |=> cfg_rdata_o[0]);

  p_status_only_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_start_i && !cmd_stop_i) |=> $stable(cfg_rdata_o[0]));

  p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[0] |-> (!tick_o && !divclk_o));

  p_cnt_in_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[0] && !wake_i) |-> (cnt_w <= last_w));

  p_wake_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (cnt_w == '0));

  p_wake_keeps_cfg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !cfg_we_i && !cmd_start_i && !cmd_stop_i) |=> $stable(cfg_rdata_o));

  p_no_divclk_frac_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_frac_w != '0) |-> !divclk_o);

endmodule

bind frac_clk_div fcd_sva #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cmd_start_i(cmd_start_i),
  .cmd_stop_i (cmd_stop_i),
  .wake_i     (wake_i),
  .cfg_rdata_o(cfg_rdata_o),
  .tick_o     (tick_o),
  .divclk_o   (divclk_o),
  .cnt_w      (cnt_w),
  .last_w     (last_w),
  .act_frac_w (act_frac_w)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic        c_on = 1'b0;
  logic        c_off = 1'b0;
  logic        wk = 1'b0;
  logic [31:0] rd;
  logic        tick;
  logic        dclk;

  frac_clk_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .cmd_start_i(c_on), .cmd_stop_i(c_off), .wake_i(wk),
    .cfg_rdata_o(rd), .tick_o(tick), .divclk_o(dclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state kept by the bench.
  bit          m_en;
  logic [23:0] m_int, m_aint;
  logic [4:0]  m_frac, m_afrac, m_acc;
  logic [24:0] m_cnt;
  bit          m_ext;

  logic [33:0] exp_q[$];
  int          tick_at[$];
  int          total = 0;
  int          bad = 0;
  int          cyc_no = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc_no);
    end
  endtask

  // Driver: one source cycle of stimulus plus the predicted outputs.
  task automatic cyc(input bit w, input logic [31:0] d, input bit on,
                     input bit off, input bit wake);
    bit          e_tick, e_div, c;
    logic [5:0]  sum;
    @(posedge clk);
    #1;
    we = w; wd = d; c_on = on; c_off = off; wk = wake;
    e_tick = m_en && !wake && (m_cnt == ({1'b0, m_aint} + 25'(m_ext)));
    e_div  = m_en && (m_afrac == 0) && (m_aint != 0) &&
             (m_cnt < (({1'b0, m_aint} + 25'd1) / 2));
    exp_q.push_back({e_tick, e_div, m_int, m_frac, 2'b00, m_en});
    if (!m_en || wake) begin
      m_cnt = 0; m_acc = 0; m_ext = 0; m_aint = m_int; m_afrac = m_frac;
    end else if (e_tick) begin
      sum = {1'b0, m_acc} + {1'b0, m_afrac};
      c = sum[5];
      m_acc = sum[4:0]; m_ext = c; m_cnt = 0;
      m_aint = m_int; m_afrac = m_frac;
    end else begin
      m_cnt = m_cnt + 1;
    end
    if (off) m_en = 0;
    else if (on) m_en = 1;
    if (w) begin m_int = d[31:8]; m_frac = d[7:3]; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
  endtask
  task automatic wr(input logic [31:0] d); cyc(1, d, 0, 0, 0); endtask
  task automatic start(); cyc(0, '0, 1, 0, 0); endtask
  task automatic stop(); cyc(0, '0, 0, 1, 0); endtask

  // Monitor: pops predictions and compares in the middle of each cycle.
  always @(posedge clk) begin
    logic [33:0] e;
    cyc_no++;
    #6;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(tick == e[33], "R4 tick", {31'b0, tick}, {31'b0, e[33]});
      chk(dclk == e[32], "R6/R7 divclk", {31'b0, dclk}, {31'b0, e[32]});
      chk(rd == e[31:0], "R2 word", rd, e[31:0]);
      if (tick) tick_at.push_back(cyc_no);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e_cyc, w_cyc, sum32;
    bit all_ok;
    m_en = 0; m_int = 0; m_aint = 0; m_frac = 0; m_afrac = 0;
    m_acc = 0; m_cnt = 0; m_ext = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #6;
    chk(rd == 32'h0, "R1 reset word", rd, 32'h0);
    chk(!tick && !dclk, "R1 outputs low", {30'b0, tick, dclk}, 32'h0);

    // Field positions; status and spare bits of a write are dropped.
    wr({24'd0, 5'd17, 3'b111});
    idle(1); #6;
    chk(rd == 32'h0000_0088, "R2 frac field", rd, 32'h0000_0088);
    wr({24'd3, 5'd0, 3'b111});
    idle(1); #6;
    chk(rd == 32'h0000_0300, "R3 status not writable", rd, 32'h0000_0300);
    idle(5); #6;
    chk(!tick && !dclk, "R8 quiet while stopped", {30'b0, tick, dclk}, 32'h0);

    // Integer ratio 4.
    tick_at.delete();
    start();
    e_cyc = cyc_no;
    idle(20); #6;
    chk(tick_at.size() >= 4, "R4 tick count", tick_at.size(), 4);
    if (tick_at.size() > 0)
      chk(tick_at[0] - e_cyc == 4, "R8 first tick after start", tick_at[0] - e_cyc, 4);
    all_ok = 1;
    for (int i = 1; i < tick_at.size(); i++) if (tick_at[i] - tick_at[i-1] != 4) all_ok = 0;
    chk(all_ok, "R4 period of 4", {31'b0, all_ok}, 1);

    // Simultaneous commands.
    cyc(0, '0, 1, 1, 0);
    idle(1); #6;
    chk(rd[0] == 1'b0, "R3 stop wins", {31'b0, rd[0]}, 0);

    // Ratio 5: divclk high two cycles.
    wr({24'd4, 5'd0, 3'b0});
    start();
    idle(25);
    stop();

    // Fractional ratio 3 + 5/32.
    wr({24'd2, 5'd5, 3'b0});
    tick_at.delete();
    start();
    idle(130); #6;
    chk(tick_at.size() >= 33, "R5 enough ticks", tick_at.size(), 33);
    if (tick_at.size() >= 33) begin
      sum32 = tick_at[32] - tick_at[0];
      chk(sum32 == 101, "R5 32-period total", sum32, 101);
    end
    all_ok = 1;
    for (int i = 1; i < tick_at.size(); i++)
      if (tick_at[i] - tick_at[i-1] != 3 && tick_at[i] - tick_at[i-1] != 4) all_ok = 0;
    chk(all_ok, "R5 jitter one cycle", {31'b0, all_ok}, 1);
    stop();

    // INT = 0: tick every cycle, no divided clock.
    wr(32'h0);
    tick_at.delete();
    start();
    idle(10); #6;
    chk(tick_at.size() == 10, "R7 tick every cycle", tick_at.size(), 10);
    stop();

    // Mid-period ratio change.
    wr({24'd5, 5'd0, 3'b0});
    tick_at.delete();
    start();
    e_cyc = cyc_no;
    idle(2);
    wr({24'd1, 5'd0, 3'b0});
    idle(12); #6;
    chk(tick_at.size() >= 3, "R9 ticks seen", tick_at.size(), 3);
    if (tick_at.size() >= 3) begin
      chk(tick_at[0] - e_cyc == 6, "R9 old period kept", tick_at[0] - e_cyc, 6);
      chk(tick_at[1] - tick_at[0] == 2, "R9 new period used", tick_at[1] - tick_at[0], 2);
    end
    stop();

    // Wake-up while running.
    wr({24'd5, 5'd0, 3'b0});
    start();
    idle(8);
    tick_at.delete();
    cyc(0, '0, 0, 0, 1);
    w_cyc = cyc_no;
    idle(12); #6;
    chk(rd == 32'h0000_0501, "R10 config kept", rd, 32'h0000_0501);
    chk(tick_at.size() >= 1, "R10 runs on", tick_at.size(), 1);
    if (tick_at.size() >= 1)
      chk(tick_at[0] - w_cyc == 6, "R10 restart from zero", tick_at[0] - w_cyc, 6);

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule